// File: doc/BRIEF.md
# Three-Class Link Traffic Steering Unit

This block is the sending side of one cluster's port onto a global interconnect that has three parallel classes of wire. The classes differ in width and delivery latency. The fast class is narrow and delivers in one cycle. The baseline class is medium width and delivers in two cycles. The low-power class is wide and delivers in three cycles. Each cycle the block looks at five request sources, each with its own valid/ready handshake:

- partial address: the low-order effective-address bits of a load or store, sent ahead of the full address;
- narrow operand: an integer result predicted to fit in ten bits;
- critical operand: any other full-width value;
- remote operand: a source operand copied to a remote register file at dispatch;
- store data.

The block chooses a wire class for each request and places the payload in that class's width. It then pushes the transfer into a fixed-latency delay pipeline that models the link. The transfer appears at the receiver side of that class after the class's cycle count.

Partial addresses and narrow operands want the fast class. A partial address always wins it. A displaced narrow operand falls back to the baseline class. A critical operand that then finds the baseline class taken is stalled by deasserting its ready. Remote operands and store data are not latency critical. They share the wide class, each in a slot of its own. Every class keeps transfers in issue order.

Top module: `link_steer`

## Requirements
- R1: While reset is asserted, every output valid (`fast_vld`, `base_vld`, both bits of `wide_vld`) is cleared. They read 0 in the first cycle after reset.
- R2: A partial-address request is always ready. It leaves on the fast class one clock edge after acceptance with tag 1 and `fast_data` equal to `pa_addr`.
- R3: A narrow operand with no partial address in the same cycle leaves on the fast class one edge after acceptance. It carries tag 2 and is zero-extended into `fast_data`.
- R4: A narrow operand offered in the same cycle as a partial address is still accepted. It leaves on the baseline class two edges later with tag 2, zero-extended into `base_data`.
- R5: An accepted critical operand leaves on the baseline class two edges after acceptance with tag 3. `base_data` holds the operand zero-extended.
- R6: When a partial address, a narrow operand and a critical operand are all valid in one cycle, `cr_rdy` is 0. The critical operand is not sent that cycle. With only a narrow operand and a critical operand valid, both are accepted.
- R7: Remote operands and store data are always ready. They leave on the wide class three edges after acceptance. A remote operand goes in slot 0 (`wide_data[71:0]`, `wide_vld[0]`, `wide_tag[2:0]` = 4). Store data goes in slot 1 (`wide_data[143:72]`, `wide_vld[1]`, `wide_tag[5:3]` = 5). Both may go in one cycle.
- R8: Transfers accepted on consecutive cycles for one class come out on consecutive cycles in the order they were accepted.
- R9: A class whose inputs carry no accepted request in a cycle shows valid 0 at its output when that cycle's latency has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_vld | input | 1 | Partial-address request valid |
| pa_rdy | output | 1 | Partial-address request ready |
| pa_addr | input | 18 | Low-order address bits |
| nw_vld | input | 1 | Narrow operand valid |
| nw_rdy | output | 1 | Narrow operand ready |
| nw_val | input | 10 | Narrow operand value |
| cr_vld | input | 1 | Critical operand valid |
| cr_rdy | output | 1 | Critical operand ready |
| cr_val | input | 64 | Critical operand value |
| ro_vld | input | 1 | Remote-operand valid |
| ro_rdy | output | 1 | Remote-operand ready |
| ro_val | input | 64 | Remote-operand value |
| st_vld | input | 1 | Store data valid |
| st_rdy | output | 1 | Store data ready |
| st_val | input | 64 | Store data value |
| fast_vld | output | 1 | Fast-class output valid |
| fast_tag | output | 3 | Fast-class transfer type |
| fast_data | output | 18 | Fast-class payload |
| base_vld | output | 1 | Baseline-class output valid |
| base_tag | output | 3 | Baseline-class transfer type |
| base_data | output | 72 | Baseline-class payload |
| wide_vld | output | 2 | Wide-class slot valids |
| wide_tag | output | 6 | Wide-class slot types, slot 0 low |
| wide_data | output | 144 | Wide-class payload, slot 0 low |

## Verification
Two decisions can fall in the same cycle. One is the partial address taking the fast class; that forces the narrow operand onto the baseline class. The other is the baseline class being claimed by a critical operand. The bench raises the partial-address, narrow and critical valids together and holds the critical request until it is accepted. It then judges three things. `cr_rdy` must be low in the colliding cycle. The baseline output two cycles later must carry the narrow tag and value. The critical operand must appear on the baseline class only after the cycle in which its ready returned.

// File: rtl/link_steer_pkg.sv
package link_steer_pkg;
  localparam int TAG_W = 3;

  typedef enum logic [TAG_W-1:0] {
    TAG_NONE   = 3'd0,
    TAG_PADDR  = 3'd1,
    TAG_NARROW = 3'd2,
    TAG_CRIT   = 3'd3,
    TAG_REMOTE = 3'd4,
    TAG_STORE  = 3'd5
  } xfer_tag_e;
endpackage

// File: rtl/link_steer_arb.sv
module link_steer_arb
  import link_steer_pkg::*;
#(
  parameter int FAST_W   = 18,
  parameter int BASE_W   = 72,
  parameter int WSLOT_W  = 72,
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 10
) (
  input  logic                  pa_vld,
  input  logic [FAST_W-1:0]     pa_addr,
  input  logic                  nw_vld,
  input  logic [NARROW_W-1:0]   nw_val,
  input  logic                  cr_vld,
  input  logic [DATA_W-1:0]     cr_val,
  input  logic                  ro_vld,
  input  logic [DATA_W-1:0]     ro_val,
  input  logic                  st_vld,
  input  logic [DATA_W-1:0]     st_val,
  output logic                  pa_rdy,
  output logic                  nw_rdy,
  output logic                  cr_rdy,
  output logic                  ro_rdy,
  output logic                  st_rdy,
  output logic                  fast_vld,
  output logic [TAG_W-1:0]      fast_tag,
  output logic [FAST_W-1:0]     fast_data,
  output logic                  base_vld,
  output logic [TAG_W-1:0]      base_tag,
  output logic [BASE_W-1:0]     base_data,
  output logic [1:0]            wide_vld,
  output logic [2*TAG_W-1:0]    wide_tag,
  output logic [2*WSLOT_W-1:0]  wide_data
);
  localparam int NW_FPAD = FAST_W - NARROW_W;
  localparam int NW_BPAD = BASE_W - NARROW_W;
  localparam int CR_BPAD = BASE_W - DATA_W;
  localparam int W_PAD   = WSLOT_W - DATA_W;

  logic                nw_bumped;
  logic [FAST_W-1:0]   nw_fast;
  logic [BASE_W-1:0]   nw_base;
  logic [BASE_W-1:0]   cr_base;
  logic [WSLOT_W-1:0]  ro_slot;
  logic [WSLOT_W-1:0]  st_slot;

  assign nw_fast = {{NW_FPAD{1'b0}}, nw_val};
  assign nw_base = {{NW_BPAD{1'b0}}, nw_val};
  assign cr_base = {{CR_BPAD{1'b0}}, cr_val};
  assign ro_slot = {{W_PAD{1'b0}}, ro_val};
  assign st_slot = {{W_PAD{1'b0}}, st_val};

  // Fast class: partial address outranks the narrow operand.
  always_comb begin
    nw_bumped = pa_vld && nw_vld;
    fast_vld  = pa_vld || nw_vld;
    if (pa_vld) begin
      fast_tag  = TAG_PADDR;
      fast_data = pa_addr;
    end else if (nw_vld) begin
      fast_tag  = TAG_NARROW;
      fast_data = nw_fast;
    end else begin
      fast_tag  = TAG_NONE;
      fast_data = pa_addr;
    end
  end

  // Baseline class: displaced narrow operand outranks the critical operand.
  always_comb begin
    if (nw_bumped) begin
      base_vld  = 1'b1;
      base_tag  = TAG_NARROW;
      base_data = nw_base;
    end else if (cr_vld) begin
      base_vld  = 1'b1;
      base_tag  = TAG_CRIT;
      base_data = cr_base;
    end else begin
      base_vld  = 1'b0;
      base_tag  = TAG_NONE;
      base_data = cr_base;
    end
  end

  // Wide class: one slot per non-critical source.
  always_comb begin
    wide_vld  = {st_vld, ro_vld};
    wide_tag  = {(st_vld ? TAG_STORE : TAG_NONE), (ro_vld ? TAG_REMOTE : TAG_NONE)};
    wide_data = {st_slot, ro_slot};
  end

  assign pa_rdy = 1'b1;
  assign nw_rdy = 1'b1;
  assign cr_rdy = !nw_bumped;
  assign ro_rdy = 1'b1;
  assign st_rdy = 1'b1;
endmodule

// File: rtl/link_lane_pipe.sv
module link_lane_pipe
  import link_steer_pkg::*;
#(
  parameter int W     = 72,
  parameter int SLOTS = 1,
  parameter int LAT   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       in_vld,
  input  logic [SLOTS*TAG_W-1:0] in_tag,
  input  logic [W-1:0]           in_data,
  output logic [SLOTS-1:0]       out_vld,
  output logic [SLOTS*TAG_W-1:0] out_tag,
  output logic [W-1:0]           out_data
);
  localparam int LAST = LAT - 1;

  logic [LAT-1:0][SLOTS-1:0]       vld_q;
  logic [LAT-1:0][SLOTS*TAG_W-1:0] tag_q;
  logic [LAT-1:0][W-1:0]           dat_q;

  // Valid bits take the reset; payload stages stay free for shift-register inference.
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q[0] <= in_vld;
    tag_q[0] <= in_tag;
    dat_q[0] <= in_data;
  end

  generate
    for (genvar s = 1; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld_q[s] <= '0;
        else     vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  endgenerate

  assign out_vld  = vld_q[LAST];
  assign out_tag  = tag_q[LAST];
  assign out_data = dat_q[LAST];
endmodule

// File: rtl/link_steer.sv
module link_steer
  import link_steer_pkg::*;
#(
  parameter int FAST_W   = 18,
  parameter int BASE_W   = 72,
  parameter int WIDE_W   = 144,
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 10,
  parameter int FAST_LAT = 1,
  parameter int BASE_LAT = 2,
  parameter int WIDE_LAT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pa_vld,
  output logic                pa_rdy,
  input  logic [FAST_W-1:0]   pa_addr,
  input  logic                nw_vld,
  output logic                nw_rdy,
  input  logic [NARROW_W-1:0] nw_val,
  input  logic                cr_vld,
  output logic                cr_rdy,
  input  logic [DATA_W-1:0]   cr_val,
  input  logic                ro_vld,
  output logic                ro_rdy,
  input  logic [DATA_W-1:0]   ro_val,
  input  logic                st_vld,
  output logic                st_rdy,
  input  logic [DATA_W-1:0]   st_val,
  output logic                fast_vld,
  output logic [2:0]          fast_tag,
  output logic [FAST_W-1:0]   fast_data,
  output logic                base_vld,
  output logic [2:0]          base_tag,
  output logic [BASE_W-1:0]   base_data,
  output logic [1:0]          wide_vld,
  output logic [5:0]          wide_tag,
  output logic [WIDE_W-1:0]   wide_data
);
  localparam int WSLOT_W = WIDE_W / 2;

  logic                 s_fast_vld, s_base_vld;
  logic [TAG_W-1:0]     s_fast_tag, s_base_tag;
  logic [FAST_W-1:0]    s_fast_data;
  logic [BASE_W-1:0]    s_base_data;
  logic [1:0]           s_wide_vld;
  logic [2*TAG_W-1:0]   s_wide_tag;
  logic [2*WSLOT_W-1:0] s_wide_data;

  link_steer_arb #(
    .FAST_W(FAST_W), .BASE_W(BASE_W), .WSLOT_W(WSLOT_W),
    .DATA_W(DATA_W), .NARROW_W(NARROW_W)
  ) u_arb (
    .pa_vld(pa_vld), .pa_addr(pa_addr),
    .nw_vld(nw_vld), .nw_val(nw_val),
    .cr_vld(cr_vld), .cr_val(cr_val),
    .ro_vld(ro_vld), .ro_val(ro_val),
    .st_vld(st_vld), .st_val(st_val),
    .pa_rdy(pa_rdy), .nw_rdy(nw_rdy), .cr_rdy(cr_rdy),
    .ro_rdy(ro_rdy), .st_rdy(st_rdy),
    .fast_vld(s_fast_vld), .fast_tag(s_fast_tag), .fast_data(s_fast_data),
    .base_vld(s_base_vld), .base_tag(s_base_tag), .base_data(s_base_data),
    .wide_vld(s_wide_vld), .wide_tag(s_wide_tag), .wide_data(s_wide_data)
  );

  link_lane_pipe #(.W(FAST_W), .SLOTS(1), .LAT(FAST_LAT)) u_fast (
    .clk(clk), .rst(rst),
    .in_vld(s_fast_vld), .in_tag(s_fast_tag), .in_data(s_fast_data),
    .out_vld(fast_vld), .out_tag(fast_tag), .out_data(fast_data)
  );

  link_lane_pipe #(.W(BASE_W), .SLOTS(1), .LAT(BASE_LAT)) u_base (
    .clk(clk), .rst(rst),
    .in_vld(s_base_vld), .in_tag(s_base_tag), .in_data(s_base_data),
    .out_vld(base_vld), .out_tag(base_tag), .out_data(base_data)
  );

  link_lane_pipe #(.W(WIDE_W), .SLOTS(2), .LAT(WIDE_LAT)) u_wide (
    .clk(clk), .rst(rst),
    .in_vld(s_wide_vld), .in_tag(s_wide_tag), .in_data(s_wide_data),
    .out_vld(wide_vld), .out_tag(wide_tag), .out_data(wide_data)
  );
endmodule

// File: rtl/link_steer_chk.sv
module link_steer_chk #(
  parameter int FAST_W = 18,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              pa_vld,
  input logic [FAST_W-1:0] pa_addr,
  input logic              nw_vld,
  input logic              cr_vld,
  input logic              cr_rdy,
  input logic [DATA_W-1:0] cr_val,
  input logic              st_vld,
  input logic              st_rdy,
  input logic              fast_vld,
  input logic [2:0]        fast_tag,
  input logic [FAST_W-1:0] fast_data,
  input logic              base_vld,
  input logic [2:0]        base_tag,
  input logic [71:0]       base_data,
  input logic [1:0]        wide_vld,
  input logic [5:0]        wide_tag
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!fast_vld && !base_vld && wide_vld == 2'b00));

  p_paddr_fast_r2: assert property (@(posedge clk) disable iff (rst)
    pa_vld |=> (fast_vld && fast_tag == 3'd1 && fast_data == $past(pa_addr)));

  p_narrow_fast_r3: assert property (@(posedge clk) disable iff (rst)
    (nw_vld && !pa_vld) |=> (fast_vld && fast_tag == 3'd2));

  p_narrow_fallback_r4: assert property (@(posedge clk) disable iff (rst)
    (nw_vld && pa_vld) |=> ##1 (base_vld && base_tag == 3'd2));

  p_crit_base_r5: assert property (@(posedge clk) disable iff (rst)
    (cr_vld && cr_rdy) |=> ##1 (base_vld && base_tag == 3'd3 &&
                                base_data[DATA_W-1:0] == $past(cr_val, 2)));

  p_stall_no_send_r6: assert property (@(posedge clk) disable iff (rst)
    (cr_vld && !cr_rdy) |=> ##1 (base_tag != 3'd3));

  p_store_wide_r7: assert property (@(posedge clk) disable iff (rst)
    (st_vld && st_rdy) |=> ##2 (wide_vld[1] && wide_tag[5:3] == 3'd5));

  p_idle_fast_r9: assert property (@(posedge clk) disable iff (rst)
    (!pa_vld && !nw_vld) |=> !fast_vld);
endmodule

bind link_steer link_steer_chk #(.FAST_W(FAST_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .pa_vld(pa_vld), .pa_addr(pa_addr), .nw_vld(nw_vld),
  .cr_vld(cr_vld), .cr_rdy(cr_rdy), .cr_val(cr_val),
  .st_vld(st_vld), .st_rdy(st_rdy),
  .fast_vld(fast_vld), .fast_tag(fast_tag), .fast_data(fast_data),
  .base_vld(base_vld), .base_tag(base_tag), .base_data(base_data),
  .wide_vld(wide_vld), .wide_tag(wide_tag)
);

// File: tb/tb_link_steer.sv
`timescale 1ns/1ps
module tb_link_steer;
  logic clk = 1'b0;
  logic rst;
  logic pa_vld, pa_rdy;  logic [17:0] pa_addr;
  logic nw_vld, nw_rdy;  logic [9:0]  nw_val;
  logic cr_vld, cr_rdy;  logic [63:0] cr_val;
  logic ro_vld, ro_rdy;  logic [63:0] ro_val;
  logic st_vld, st_rdy;  logic [63:0] st_val;
  logic fast_vld;  logic [2:0] fast_tag;  logic [17:0]  fast_data;
  logic base_vld;  logic [2:0] base_tag;  logic [71:0]  base_data;
  logic [1:0] wide_vld; logic [5:0] wide_tag; logic [143:0] wide_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_steer dut (
    .clk(clk), .rst(rst),
    .pa_vld(pa_vld), .pa_rdy(pa_rdy), .pa_addr(pa_addr),
    .nw_vld(nw_vld), .nw_rdy(nw_rdy), .nw_val(nw_val),
    .cr_vld(cr_vld), .cr_rdy(cr_rdy), .cr_val(cr_val),
    .ro_vld(ro_vld), .ro_rdy(ro_rdy), .ro_val(ro_val),
    .st_vld(st_vld), .st_rdy(st_rdy), .st_val(st_val),
    .fast_vld(fast_vld), .fast_tag(fast_tag), .fast_data(fast_data),
    .base_vld(base_vld), .base_tag(base_tag), .base_data(base_data),
    .wide_vld(wide_vld), .wide_tag(wide_tag), .wide_data(wide_data)
  );

  task automatic check(input string what, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    pa_vld = 0; nw_vld = 0; cr_vld = 0; ro_vld = 0; st_vld = 0;
  endtask

  task automatic settle();
    idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 fast_vld after reset", 144'(fast_vld), 144'(0));
    check("R1 base_vld after reset", 144'(base_vld), 144'(0));
    check("R1 wide_vld after reset", 144'(wide_vld), 144'(0));
  endtask

  task automatic t_paddr();
    pa_vld = 1; pa_addr = 18'h2A5C3;
    #1 check("R2 pa_rdy", 144'(pa_rdy), 144'(1));
    @(negedge clk); idle();
    check("R2 fast_vld", 144'(fast_vld), 144'(1));
    check("R2 fast_tag", 144'(fast_tag), 144'(1));
    check("R2 fast_data", 144'(fast_data), 144'(18'h2A5C3));
    @(negedge clk);
    check("R9 base idle after lone paddr", 144'(base_vld), 144'(0));
    check("R9 fast idle next cycle", 144'(fast_vld), 144'(0));
    settle();
  endtask

  task automatic t_narrow();
    nw_vld = 1; nw_val = 10'h3A7;
    #1 check("R3 nw_rdy", 144'(nw_rdy), 144'(1));
    @(negedge clk); idle();
    check("R3 fast_vld", 144'(fast_vld), 144'(1));
    check("R3 fast_tag", 144'(fast_tag), 144'(2));
    check("R3 fast_data", 144'(fast_data), 144'(18'h003A7));
    settle();
  endtask

  task automatic t_fallback();
    pa_vld = 1; pa_addr = 18'h00F0F; nw_vld = 1; nw_val = 10'h155;
    #1 check("R4 nw_rdy with paddr", 144'(nw_rdy), 144'(1));
    @(negedge clk); idle();
    check("R4 fast carries paddr", 144'(fast_tag), 144'(1));
    @(negedge clk);
    check("R4 base_vld", 144'(base_vld), 144'(1));
    check("R4 base_tag", 144'(base_tag), 144'(2));
    check("R4 base_data", 144'(base_data), 144'(72'h155));
    settle();
  endtask

  task automatic t_crit();
    cr_vld = 1; cr_val = 64'hDEAD_BEEF_0123_4567;
    #1 check("R5 cr_rdy", 144'(cr_rdy), 144'(1));
    @(negedge clk); idle();
    check("R9 fast idle for crit", 144'(fast_vld), 144'(0));
    check("R5 base not yet", 144'(base_vld), 144'(0));
    @(negedge clk);
    check("R5 base_vld", 144'(base_vld), 144'(1));
    check("R5 base_tag", 144'(base_tag), 144'(3));
    check("R5 base_data", 144'(base_data), 144'(64'hDEAD_BEEF_0123_4567));
    settle();
  endtask

  task automatic t_stall();
    // narrow and critical alone: both accepted
    nw_vld = 1; nw_val = 10'h0C3; cr_vld = 1; cr_val = 64'h1111_2222_3333_4444;
    #1 check("R6 cr_rdy without paddr", 144'(cr_rdy), 144'(1));
    @(negedge clk); idle();
    check("R6 fast carries narrow", 144'(fast_tag), 144'(2));
    @(negedge clk);
    check("R6 base carries crit", 144'(base_tag), 144'(3));
    settle();
    // three-way collision: critical stalls, held until accepted
    pa_vld = 1; pa_addr = 18'h1; nw_vld = 1; nw_val = 10'h2AA;
    cr_vld = 1; cr_val = 64'hCAFE_0000_0000_0042;
    #1 check("R6 cr_rdy low on collision", 144'(cr_rdy), 144'(0));
    @(negedge clk);
    pa_vld = 0; nw_vld = 0;
    #1 check("R6 cr_rdy back", 144'(cr_rdy), 144'(1));
    @(negedge clk); idle();
    check("R6 base carries narrow", 144'(base_tag), 144'(2));
    check("R6 base narrow data", 144'(base_data), 144'(72'h2AA));
    @(negedge clk);
    check("R6 crit after release tag", 144'(base_tag), 144'(3));
    check("R6 crit after release data", 144'(base_data), 144'(64'hCAFE_0000_0000_0042));
    settle();
  endtask

  task automatic t_wide();
    ro_vld = 1; ro_val = 64'hA0A0_B1B1_C2C2_D3D3;
    st_vld = 1; st_val = 64'h0102_0304_0506_0708;
    #1 check("R7 ro_rdy", 144'(ro_rdy), 144'(1));
    check("R7 st_rdy", 144'(st_rdy), 144'(1));
    @(negedge clk); idle();
    @(negedge clk);
    check("R7 wide not yet", 144'(wide_vld), 144'(0));
    @(negedge clk);
    check("R7 wide_vld both", 144'(wide_vld), 144'(2'b11));
    check("R7 wide_tag", 144'(wide_tag), 144'({3'd5, 3'd4}));
    check("R7 wide_data", wide_data,
          {8'h00, 64'h0102_0304_0506_0708, 8'h00, 64'hA0A0_B1B1_C2C2_D3D3});
    settle();
    st_vld = 1; st_val = 64'h77;
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    check("R7 store alone slot1", 144'(wide_vld), 144'(2'b10));
    check("R7 store alone data", 144'(wide_data[143:72]), 144'(64'h77));
    settle();
  endtask

  task automatic t_order();
    logic [63:0] vals [3];
    vals[0] = 64'h10; vals[1] = 64'h20; vals[2] = 64'h30;
    for (int j = 0; j < 5; j++) begin
      if (j >= 2) check("R8 base order", 144'(base_data), 144'(vals[j-2]));
      if (j < 3) begin
        cr_vld = 1; cr_val = vals[j];
        pa_vld = 1; pa_addr = 18'(j + 5);
      end else idle();
      @(negedge clk);
      if (j < 3) check("R8 fast order", 144'(fast_data), 144'(j + 5));
    end
    check("R9 base drains", 144'(base_vld), 144'(0));
    settle();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pa_addr = 0; nw_val = 0; cr_val = 0; ro_val = 0; st_val = 0;
    idle();
    rst = 1;
    @(negedge clk);
    t_reset();
    t_paddr();
    t_narrow();
    t_fallback();
    t_crit();
    t_stall();
    t_wide();
    t_order();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule